// File: doc/BRIEF.md
# Two-Wire Slave Command Front End

This block is the serial front end of a small register engine. It watches a two-wire bus (clock line and open-drain data line) with a fast system clock, and finds start and stop conditions. It collects an identification byte, an instruction byte and, for write commands, one data byte. A matching transaction is turned into a one-cycle command strobe that carries the decoded opcode, register selector, pot selector and data.

For read commands the block returns one byte from the engine, most significant bit first. It controls the data line only through an active-high pull-down enable. While the engine reports that a long internal write is still running, the block refuses to acknowledge its own address. A bus master can therefore repeat the address until it is acknowledged, and so learn when the write has finished. A stop condition is passed on as a pulse, which the engine uses to launch such a write.

Top module: `twowire_cmd_slave`

## Requirements
- R1: After reset, `sda_pull_o`, `cmd_valid_o` and `bus_stop_o` are low.
- R2: Until a start condition (data line falling while the clock line is high) is seen, clocked bus traffic gets no acknowledge and issues no command.
- R3: The identification byte is acknowledged only when its upper nibble is 4'b0101 and its lower nibble equals `addr_pins_i`. On a mismatch the block does not acknowledge and ignores the bus until the next start.
- R4: The instruction byte is acknowledged. Bits [7:4] are the opcode, bits [3:2] the register selector, bit 1 is reserved and bit 0 is the pot selector, most significant bit first on the bus.
- R5: Opcodes 4'b1010 and 4'b1100 take one data byte, which is acknowledged. A single-cycle `cmd_valid_o` then presents the fields and `cmd_data_o`.
- R6: Any other opcode that is not a read issues a single-cycle `cmd_valid_o` after the instruction byte. A byte sent after it is not acknowledged.
- R7: Opcodes 4'b1001 and 4'b1011 issue `cmd_valid_o` after the instruction byte. After its acknowledge, `rd_data_i` is sent MSB first, and the data line is released during the master's ninth clock.
- R8: While `eng_busy_i` is high at the eighth address bit, the address is not acknowledged. Once it is low, the same address is acknowledged.
- R9: A stop condition (data line rising while the clock line is high) returns the block to idle and pulses `bus_stop_o` for one cycle.
- R10: A start condition seen in the middle of any byte aborts that transfer and restarts reception at the identification byte.
- R11: `sda_pull_o` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins_i | input | 4 | Strapped low nibble of the slave address |
| eng_busy_i | input | 1 | Engine is running a long internal write |
| rd_data_i | input | 8 | Read data returned by the engine |
| sda_pull_o | output | 1 | High pulls the data line low |
| cmd_valid_o | output | 1 | One-cycle strobe: a command is complete |
| cmd_opcode_o | output | 4 | Decoded opcode |
| cmd_regsel_o | output | 2 | Register selector |
| cmd_pot_o | output | 1 | Pot selector |
| cmd_data_o | output | 8 | Data byte of a write command |
| bus_stop_o | output | 1 | One-cycle pulse on each stop condition |

## Verification
The busy flag from the engine and the completion of the address byte can meet in the same system cycle. The acknowledge decision is taken from the busy level at the eighth rising clock edge. The bench moves the busy edge to different places within the address byte: it drops busy midway through the byte and expects an acknowledge, and it raises busy after the eighth bit and still expects one. A repeated start and bit reception can also collide. A start is injected after four instruction bits, and the bench expects a clean new transaction with no stray command.

// File: rtl/tw_cmd_pkg.sv
package tw_cmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } tw_state_e;

   typedef enum logic [1:0] {
      BY_ID,
      BY_INS,
      BY_DAT
   } tw_byte_e;

   localparam logic [3:0] OP_RD_WIPER = 4'b1001;
   localparam logic [3:0] OP_WR_WIPER = 4'b1010;
   localparam logic [3:0] OP_RD_DREG  = 4'b1011;
   localparam logic [3:0] OP_WR_DREG  = 4'b1100;

   typedef struct packed {
      logic [3:0] opcode;
      logic [1:0] regsel;
      logic       pot;
   } tw_cmd_t;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int               STAGES    = 2,
   parameter int               WIDTH     = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tw_line_sync needs at least two stages");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tw_line_sync needs a positive width");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
   assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tw_instr_decode.sv
module tw_instr_decode
   import tw_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] byte_i,
   output tw_cmd_t           cmd_o,
   output logic              is_read_o,
   output logic              needs_data_o
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("instruction byte layout needs eight bits");
      end
   endgenerate

   always_comb begin
      cmd_o.opcode = byte_i[7:4];
      cmd_o.regsel = byte_i[3:2];
      cmd_o.pot    = byte_i[0];
      is_read_o    = 1'b0;
      needs_data_o = 1'b0;
      case (byte_i[7:4])
         OP_RD_WIPER, OP_RD_DREG: is_read_o    = 1'b1;
         OP_WR_WIPER, OP_WR_DREG: needs_data_o = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave
   import tw_cmd_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_TYPE    = 4'b0101,
   parameter int         DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [3:0]        addr_pins_i,
   input  logic              eng_busy_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              sda_pull_o,
   output logic              cmd_valid_o,
   output logic [3:0]        cmd_opcode_o,
   output logic [1:0]        cmd_regsel_o,
   output logic              cmd_pot_o,
   output logic [DATA_W-1:0] cmd_data_o,
   output logic              bus_stop_o
);

   localparam int               CNT_W    = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("twowire_cmd_slave carries eight-bit bytes only");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   tw_line_sync #(
      .STAGES   (SYNC_STAGES),
      .WIDTH    (2),
      .RESET_VAL(2'b11)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({scl_i, sda_i}),
      .q_o  ({scl_s, sda_s})
   );

   tw_bus_events u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise_o(scl_rise),
      .scl_fall_o(scl_fall),
      .start_o   (start_ev),
      .stop_o    (stop_ev)
   );

   tw_state_e         st;
   tw_byte_e          stage;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg, txsh, data_q;
   logic              byte_full, ack_ok, is_read_q, needs_data_q;
   logic              pull_q, valid_q, stop_q;
   tw_cmd_t           cmd_q;

   logic [DATA_W-1:0] full_byte;
   tw_cmd_t           dec_cmd;
   logic              dec_read, dec_data, addr_hit;

   assign full_byte = {shreg[DATA_W-2:0], sda_s};
   assign addr_hit  = (full_byte[7:4] == DEV_TYPE) && (full_byte[3:0] == addr_pins_i);

   tw_instr_decode #(.DATA_W(DATA_W)) u_decode (
      .byte_i      (full_byte),
      .cmd_o       (dec_cmd),
      .is_read_o   (dec_read),
      .needs_data_o(dec_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         stage        <= BY_ID;
         cnt          <= '0;
         shreg        <= '0;
         txsh         <= '0;
         data_q       <= '0;
         byte_full    <= 1'b0;
         ack_ok       <= 1'b0;
         is_read_q    <= 1'b0;
         needs_data_q <= 1'b0;
         pull_q       <= 1'b0;
         valid_q      <= 1'b0;
         stop_q       <= 1'b0;
         cmd_q        <= '0;
      end else begin
         valid_q <= 1'b0;
         stop_q  <= 1'b0;
         if (start_ev) begin
            st        <= ST_RX;
            stage     <= BY_ID;
            cnt       <= '0;
            byte_full <= 1'b0;
            ack_ok    <= 1'b0;
            pull_q    <= 1'b0;
         end else if (stop_ev) begin
            st        <= ST_IDLE;
            byte_full <= 1'b0;
            pull_q    <= 1'b0;
            stop_q    <= 1'b1;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise && !byte_full) begin
                     shreg <= full_byte;
                     if (cnt == LAST_BIT) begin
                        cnt       <= '0;
                        byte_full <= 1'b1;
                        case (stage)
                           BY_ID: ack_ok <= addr_hit && !eng_busy_i;
                           BY_INS: begin
                              ack_ok       <= 1'b1;
                              cmd_q        <= dec_cmd;
                              is_read_q    <= dec_read;
                              needs_data_q <= dec_data;
                              valid_q      <= !dec_data;
                           end
                           default: begin
                              ack_ok  <= 1'b1;
                              data_q  <= full_byte;
                              valid_q <= 1'b1;
                           end
                        endcase
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end else if (scl_fall && byte_full) begin
                     byte_full <= 1'b0;
                     if (ack_ok) begin
                        st     <= ST_RX_ACK;
                        pull_q <= 1'b1;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     pull_q <= 1'b0;
                     case (stage)
                        BY_ID: begin
                           stage <= BY_INS;
                           st    <= ST_RX;
                        end
                        BY_INS: begin
                           if (is_read_q) begin
                              txsh   <= rd_data_i;
                              pull_q <= ~rd_data_i[DATA_W-1];
                              cnt    <= '0;
                              st     <= ST_TX;
                           end else if (needs_data_q) begin
                              stage <= BY_DAT;
                              st    <= ST_RX;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        default: st <= ST_IDLE;
                     endcase
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        cnt    <= '0;
                        pull_q <= 1'b0;
                        st     <= ST_TX_ACK;
                     end else begin
                        cnt    <= cnt + 1'b1;
                        txsh   <= {txsh[DATA_W-2:0], 1'b0};
                        pull_q <= ~txsh[DATA_W-2];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) st <= ST_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o   = pull_q;
   assign cmd_valid_o  = valid_q;
   assign cmd_opcode_o = cmd_q.opcode;
   assign cmd_regsel_o = cmd_q.regsel;
   assign cmd_pot_o    = cmd_q.pot;
   assign cmd_data_o   = data_q;
   assign bus_stop_o   = stop_q;

   // R11
   pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_s);

   // R10
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (st == ST_RX && stage == BY_ID && cnt == '0 && !sda_pull_o));

   // R9
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (st == ST_IDLE && bus_stop_o && !sda_pull_o));

   // R8
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RX && stage == BY_ID && !byte_full && scl_rise && cnt == LAST_BIT
       && eng_busy_i) |=> !ack_ok);

   // R5
   cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o);

   // R7
   tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX_ACK) |-> !sda_pull_o);

endmodule

// File: tb/twowire_cmd_slave_bench.sv
`timescale 1ns/1ps
module twowire_cmd_slave_bench;

   localparam time QT = 40ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [3:0] pins = 4'hA;
   logic       busy = 1'b0;
   logic [7:0] rdata = 8'h00;

   logic       sda_pull, cmd_valid, cmd_pot, bus_stop;
   logic [3:0] cmd_op;
   logic [1:0] cmd_reg;
   logic [7:0] cmd_data;
   wire        sda_line = sda_m & ~sda_pull;

   int n_chk = 0;
   int n_err = 0;
   int cmd_cnt = 0;
   int stop_cnt = 0;
   logic [3:0] cap_op;
   logic [1:0] cap_reg;
   logic       cap_pot;
   logic [7:0] cap_data;

   always #2.5ns clk = ~clk;

   twowire_cmd_slave u_twowire_cmd_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .addr_pins_i (pins),
      .eng_busy_i  (busy),
      .rd_data_i   (rdata),
      .sda_pull_o  (sda_pull),
      .cmd_valid_o (cmd_valid),
      .cmd_opcode_o(cmd_op),
      .cmd_regsel_o(cmd_reg),
      .cmd_pot_o   (cmd_pot),
      .cmd_data_o  (cmd_data),
      .bus_stop_o  (bus_stop)
   );

   always @(negedge clk) begin
      if (cmd_valid) begin
         cmd_cnt++;
         cap_op   = cmd_op;
         cap_reg  = cmd_reg;
         cap_pot  = cmd_pot;
         cap_data = cmd_data;
      end
      if (bus_stop) stop_cnt++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; #QT;
      scl_m = 1'b1; #QT;
      sda_m = 1'b0; #QT;
      scl_m = 1'b0; #QT;
   endtask

   task automatic bus_stop_seq();
      sda_m = 1'b0; #QT;
      scl_m = 1'b1; #QT;
      sda_m = 1'b1; #QT;
   endtask

   task automatic clock_bit(input logic b, output logic seen);
      sda_m = b;    #QT;
      scl_m = 1'b1; #QT;
      seen = sda_line;
      #QT;
      scl_m = 1'b0; #QT;
   endtask

   task automatic send_byte_tog(input logic [7:0] b, input int tog_idx, input logic tog_val,
                                output logic acked);
      logic s;
      for (int i = 0; i < 8; i++) begin
         if (i == tog_idx) busy = tog_val;
         clock_bit(b[7-i], s);
      end
      if (tog_idx == 8) busy = tog_val;
      clock_bit(1'b1, s);
      acked = !s;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      send_byte_tog(b, 99, 1'b0, acked);
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic m_ack);
      logic s;
      for (int i = 0; i < 8; i++) begin
         clock_bit(1'b1, s);
         b[7-i] = s;
      end
      clock_bit(!m_ack, s);
   endtask

   task automatic t_reset();
      check(sda_pull == 1'b0, "R1 pull", sda_pull, 0);
      check(cmd_valid == 1'b0, "R1 valid", cmd_valid, 0);
      check(bus_stop == 1'b0, "R1 stop", bus_stop, 0);
   endtask

   task automatic t_no_start();
      logic a;
      int c0 = cmd_cnt;
      scl_m = 1'b0; #QT;
      send_byte(8'h5A, a);
      check(a == 1'b0, "R2 ack before start", a, 0);
      send_byte(8'h1C, a);
      check(a == 1'b0 && cmd_cnt == c0, "R2 cmd before start", cmd_cnt - c0, 0);
      bus_stop_seq();
   endtask

   task automatic t_write_wiper();
      logic a1, a2, a3;
      int c0 = cmd_cnt;
      int s0 = stop_cnt;
      bus_start();
      send_byte(8'h5A, a1);
      send_byte(8'hA1, a2);
      check(cmd_cnt == c0, "R5 no cmd before data", cmd_cnt - c0, 0);
      send_byte(8'h3C, a3);
      bus_stop_seq();
      #QT;
      check(a1, "R3 id ack", a1, 1);
      check(a2, "R4 instr ack", a2, 1);
      check(a3, "R5 data ack", a3, 1);
      check(cmd_cnt == c0 + 1, "R5 one cmd", cmd_cnt - c0, 1);
      check(cap_op == 4'b1010 && cap_reg == 2'd0 && cap_pot == 1'b1, "R4 fields",
            {cap_op, cap_reg, cap_pot}, {4'b1010, 2'd0, 1'b1});
      check(cap_data == 8'h3C, "R5 data", cap_data, 8'h3C);
      check(stop_cnt == s0 + 1, "R9 stop pulse", stop_cnt - s0, 1);
      check(sda_pull == 1'b0, "R9 idle after stop", sda_pull, 0);
   endtask

   task automatic t_write_dreg();
      logic a1, a2, a3;
      bus_start();
      send_byte(8'h5A, a1);
      send_byte(8'hC8, a2);
      send_byte(8'hE7, a3);
      bus_stop_seq();
      #QT;
      check(a1 && a2 && a3, "R5 acks dreg", {a1, a2, a3}, 3'b111);
      check(cap_op == 4'b1100 && cap_reg == 2'd2 && cap_pot == 1'b0 && cap_data == 8'hE7,
            "R4 dreg fields", {cap_op, cap_reg, cap_pot, cap_data}, {4'b1100, 2'd2, 1'b0, 8'hE7});
   endtask

   task automatic t_mismatch();
      logic a1, a2;
      int c0 = cmd_cnt;
      bus_start();
      send_byte(8'h5B, a1);
      send_byte(8'h1C, a2);
      bus_stop_seq();
      check(a1 == 1'b0, "R3 pin mismatch nack", a1, 0);
      check(a2 == 1'b0 && cmd_cnt == c0, "R3 ignored after nack", cmd_cnt - c0, 0);
      bus_start();
      send_byte(8'h6A, a1);
      bus_stop_seq();
      check(a1 == 1'b0, "R3 type mismatch nack", a1, 0);
   endtask

   task automatic t_read();
      logic a1, a2;
      logic [7:0] got;
      int c0 = cmd_cnt;
      rdata = 8'hB4;
      bus_start();
      send_byte(8'h5A, a1);
      send_byte(8'hB5, a2);
      recv_byte(got, 1'b0);
      check(sda_pull == 1'b0, "R7 released after byte", sda_pull, 0);
      bus_stop_seq();
      check(a1 && a2, "R7 read acks", {a1, a2}, 2'b11);
      check(got == 8'hB4, "R7 read data", got, 8'hB4);
      check(cmd_cnt == c0 + 1 && cap_op == 4'b1011 && cap_reg == 2'd1 && cap_pot,
            "R7 read cmd", {cap_op, cap_reg, cap_pot}, {4'b1011, 2'd1, 1'b1});
      rdata = 8'h5A;
      bus_start();
      send_byte(8'h5A, a1);
      send_byte(8'h90, a2);
      recv_byte(got, 1'b1);
      bus_stop_seq();
      check(got == 8'h5A && cap_op == 4'b1001, "R7 read wiper", got, 8'h5A);
   endtask

   task automatic t_global();
      logic a1, a2, a3;
      int c0 = cmd_cnt;
      bus_start();
      send_byte(8'h5A, a1);
      send_byte(8'h1C, a2);
      send_byte(8'h55, a3);
      bus_stop_seq();
      check(a2 && !a3, "R6 data after no-data cmd nacked", {a2, a3}, 2'b10);
      check(cmd_cnt == c0 + 1 && cap_op == 4'b0001 && cap_reg == 2'd3 && !cap_pot,
            "R6 cmd fields", {cap_op, cap_reg, cap_pot}, {4'b0001, 2'd3, 1'b0});
   endtask

   task automatic t_busy();
      logic a;
      busy = 1'b1;
      bus_start();
      send_byte(8'h5A, a);
      bus_stop_seq();
      check(a == 1'b0, "R8 busy nack", a, 0);
      bus_start();
      send_byte_tog(8'h5A, 4, 1'b0, a);
      bus_stop_seq();
      check(a == 1'b1, "R8 busy cleared mid byte", a, 1);
      bus_start();
      send_byte_tog(8'h5A, 8, 1'b1, a);
      bus_stop_seq();
      check(a == 1'b1, "R8 busy after decision", a, 1);
      busy = 1'b0;
      bus_start();
      send_byte(8'h5A, a);
      bus_stop_seq();
      check(a == 1'b1, "R8 ack when idle", a, 1);
   endtask

   task automatic t_restart();
      logic a1, a2, a3, s;
      int c0 = cmd_cnt;
      bus_start();
      send_byte(8'h5A, a1);
      for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
      bus_start();
      check(cmd_cnt == c0, "R10 no cmd from aborted byte", cmd_cnt - c0, 0);
      send_byte(8'h5A, a1);
      send_byte(8'hA0, a2);
      send_byte(8'h11, a3);
      bus_stop_seq();
      check(a1 && a2 && a3, "R10 acks after restart", {a1, a2, a3}, 3'b111);
      check(cmd_cnt == c0 + 1 && cap_op == 4'b1010 && cap_data == 8'h11,
            "R10 cmd after restart", {cap_op, cap_data}, {4'b1010, 8'h11});
   endtask

   initial begin
      #500us;
      n_err++;
      $display("FAIL WDOG actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #50ns;
      t_reset();
      rst_n = 1'b1;
      #100ns;
      t_no_start();
      t_write_wiper();
      t_write_dreg();
      t_mismatch();
      t_read();
      t_global();
      t_busy();
      t_restart();
      #200ns;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule